// File: doc/BRIEF.md
# Interrupt Event Ring with Generation Flag

This block is a circular event ring that sits between an interrupt router and one processor thread. The router appends non-zero 31-bit event numbers; the thread reads them back in arrival order. Each slot of the ring is a 32-bit word: the low 31 bits hold the event number and the top bit holds a generation flag. The producer inverts that flag every time its write position wraps, so the consumer can tell fresh slots from stale ones without a shared occupancy count.

The consumer keeps its own toggle. A slot whose flag equals that toggle has not been written on the current pass, so the read port shows 0 ("nothing pending"). When the producer would land on a slot the consumer has not yet taken, the event is dropped and an overflow pulse is raised. Each accepted event can also raise a one-cycle notify pulse when the notify enable is set. One event code, 2^24, is reserved for inter-processor interrupts and is flagged at the read port.

Top module: `evtRing`

## Requirements
- R1: Each ring slot stores {generation flag in bit 31, event number in bits 30:0}; `popEvent` presents bits 30:0 of the oldest unread slot.
- R2: After reset the ring is empty: `popEvent` is 0 and `overflow`, `notify` and `popIsIpi` are 0.
- R3: Events come out in the order they were accepted, across any number of wraps of a DEPTH-entry ring (DEPTH a power of two, positions wrapping modulo DEPTH).
- R4: With no unread slot `popEvent` is 0, and `popReq` in that state changes nothing.
- R5: The producer flag starts at 1 and inverts on each write wrap; the consumer toggle starts at 0 and inverts on each read wrap, so a slot counts as unread only when its flag differs from the toggle.
- R6: A non-zero push while DEPTH events are unread is dropped, leaves the ring contents unchanged, and raises `overflow` for exactly the following cycle.
- R7: An accepted push with `notifyEn` high raises `notify` for exactly the following cycle; with `notifyEn` low no pulse appears.
- R8: A push of event number 0 is ignored: nothing is stored, and neither `notify` nor `overflow` rises.
- R9: `popIsIpi` is 1 exactly when `popEvent` equals 2^24 (0x1000000).
- R10: Fullness is judged before the clock edge, so a push arriving while the ring is full is dropped even when a pop is taken in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Router offers an event this cycle |
| pushEvent | input | 31 | Event number offered |
| notifyEn | input | 1 | Enable notify pulse on every accepted event |
| popReq | input | 1 | Consumer takes the head event this cycle |
| popEvent | output | 31 | Head event number, 0 when empty |
| popIsIpi | output | 1 | Head event is the inter-processor code |
| overflow | output | 1 | One-cycle pulse: previous push was dropped |
| notify | output | 1 | One-cycle pulse: previous push was accepted with notify enabled |

## Verification
A wrong generation flag or toggle shows up at once as either a stale event reappearing on `popEvent` after a wrap or the head reading 0 while events remain, so the reference model is compared every clock and long streams are run through several wraps. A pointer that skips or stalls breaks ordering on the very next pop. A bad fullness decision appears one cycle later as a missing or spurious `overflow` pulse, followed by lost or duplicated events when the ring drains.

// File: rtl/evtRingPkg.sv
package evtRingPkg;
  localparam int EVT_W = 31;
  localparam int ENTRY_W = EVT_W + 1;
  localparam logic [EVT_W-1:0] IPI_CODE = EVT_W'(1 << 24);

  typedef struct packed {
    logic wrEn;   // store an entry at the write position
    logic wrGen;  // generation flag to store with it
  } ringStrobeT;
endpackage

// File: rtl/evtRingCtrl.sv
module evtRingCtrl
  import evtRingPkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic [EVT_W-1:0] pushEvent,
  input  logic             notifyEn,
  input  logic             popReq,
  input  logic             headGen,
  output ringStrobeT       strb,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] rdIdx,
  output logic             headValid,
  output logic             overflow,
  output logic             notify
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic prodGen;
  logic consToggle;
  logic ringFull;
  logic pushLive;
  logic accept;
  logic take;

  // unread slot: flag differs from the consumer toggle
  assign headValid = (headGen != consToggle);
  assign ringFull  = (wrIdx == rdIdx) && headValid;
  assign pushLive  = pushValid && (pushEvent != '0);
  assign accept    = pushLive && !ringFull;
  assign take      = popReq && headValid;

  assign strb.wrEn  = accept;
  assign strb.wrGen = prodGen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx      <= '0;
      rdIdx      <= '0;
      prodGen    <= 1'b1;
      consToggle <= 1'b0;
      overflow   <= 1'b0;
      notify     <= 1'b0;
    end else begin
      overflow <= pushLive && ringFull;
      notify   <= accept && notifyEn;
      if (accept) begin
        wrIdx <= wrIdx + 1'b1;
        if (wrIdx == LAST) prodGen <= ~prodGen;
      end
      if (take) begin
        rdIdx <= rdIdx + 1'b1;
        if (rdIdx == LAST) consToggle <= ~consToggle;
      end
    end
  end
endmodule

// File: rtl/evtRingData.sv
module evtRingData
  import evtRingPkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ringStrobeT         strb,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [IDX_W-1:0]   rdIdx,
  input  logic [EVT_W-1:0]   wrEvent,
  output logic [ENTRY_W-1:0] headEntry
);
  logic [ENTRY_W-1:0] ring [DEPTH];

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : gSlot
      always_ff @(posedge clk) begin
        if (!rstN) begin
          ring[s] <= '0;  // flag 0 matches the reset toggle: empty
        end else if (strb.wrEn && (wrIdx == IDX_W'(s))) begin
          ring[s] <= {strb.wrGen, wrEvent};
        end
      end
    end
  endgenerate

  assign headEntry = ring[rdIdx];
endmodule

// File: rtl/evtRing.sv
module evtRing
  import evtRingPkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic [30:0]      pushEvent,
  input  logic             notifyEn,
  input  logic             popReq,
  output logic [30:0]      popEvent,
  output logic             popIsIpi,
  output logic             overflow,
  output logic             notify
);
  localparam int IDX_W = $clog2(DEPTH);

  ringStrobeT         strb;
  logic [IDX_W-1:0]   wrIdx;
  logic [IDX_W-1:0]   rdIdx;
  logic [ENTRY_W-1:0] headEntry;
  logic               headValid;

  evtRingCtrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN),
    .pushValid(pushValid), .pushEvent(pushEvent),
    .notifyEn(notifyEn), .popReq(popReq),
    .headGen(headEntry[ENTRY_W-1]),
    .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .headValid(headValid), .overflow(overflow), .notify(notify)
  );

  evtRingData #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrIdx(wrIdx), .rdIdx(rdIdx),
    .wrEvent(pushEvent), .headEntry(headEntry)
  );

  assign popEvent = headValid ? headEntry[EVT_W-1:0] : '0;
  assign popIsIpi = (popEvent == IPI_CODE);
endmodule

// File: rtl/evtRingChk.sv
module evtRingChk (
  input logic        clk,
  input logic        rstN,
  input logic        pushValid,
  input logic [30:0] pushEvent,
  input logic        notifyEn,
  input logic        popReq,
  input logic [30:0] popEvent,
  input logic        popIsIpi,
  input logic        overflow,
  input logic        notify
);
  AST_DROP_NOT_NOTIFIED: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> !notify); // R6

  AST_ZERO_PUSH_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && pushEvent == '0) |=> (!notify && !overflow)); // R8

  AST_NOTIFY_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (!notifyEn) |=> !notify); // R7

  AST_EMPTY_POP_NOOP: assert property (@(posedge clk) disable iff (!rstN)
    (popEvent == '0 && !pushValid) |=> (popEvent == '0)); // R4

  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (popEvent != '0 && !popReq) |=> $stable(popEvent)); // R3

  AST_IPI_ONLY_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    popIsIpi |-> (popEvent != '0)); // R9
endmodule

bind evtRing evtRingChk uChk (
  .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushEvent(pushEvent),
  .notifyEn(notifyEn), .popReq(popReq), .popEvent(popEvent),
  .popIsIpi(popIsIpi), .overflow(overflow), .notify(notify)
);

// File: tb/tb_evtRing.sv
`timescale 1ns/1ps
module tb_evtRing;
  localparam int DEPTH = 8;
  localparam logic [30:0] IPI = 31'h1000000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 1'b0;
  logic [30:0] pushEvent = '0;
  logic notifyEn = 1'b0;
  logic popReq = 1'b0;
  logic [30:0] popEvent;
  logic popIsIpi, overflow, notify;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // behavioural reference
  int unsigned refQ[$];
  bit expOvf = 0;
  bit expNot = 0;

  always #2 clk = ~clk;

  evtRing #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushEvent(pushEvent),
    .notifyEn(notifyEn), .popReq(popReq), .popEvent(popEvent),
    .popIsIpi(popIsIpi), .overflow(overflow), .notify(notify)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // compare all outputs against the model (called after the edge settles)
  task automatic compareAll(string req);
    longint head = (refQ.size() > 0) ? longint'(refQ[0]) : 0;
    chk((refQ.size() > 0) ? req : "R4", "popEvent", longint'(popEvent), head);
    chk("R9", "popIsIpi", longint'(popIsIpi), longint'(head == longint'(IPI)));
    chk("R6", "overflow", longint'(overflow), longint'(expOvf));
    chk("R7", "notify", longint'(notify), longint'(expNot));
  endtask

  // one cycle: drive at negedge, update model for the edge, compare after it
  task automatic cycle(bit pv, logic [30:0] ev, bit ne, bit pr, string req);
    bit full, acc, live, tk;
    @(negedge clk);
    pushValid = pv; pushEvent = ev; notifyEn = ne; popReq = pr;
    live = pv && (ev != 0);
    full = (refQ.size() == DEPTH);
    acc  = live && !full;          // R10: fullness taken before the edge
    tk   = pr && (refQ.size() > 0);
    @(posedge clk);
    expOvf = live && full;
    expNot = acc && ne;
    if (tk) void'(refQ.pop_front());
    if (acc) refQ.push_back(ev);
    @(negedge clk);
    compareAll(req);
    pushValid = 0; popReq = 0;
    @(posedge clk);
    expOvf = 0; expNot = 0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: reset state
    chk("R2", "popEvent", popEvent, 0);
    chk("R2", "overflow", overflow, 0);
    chk("R2", "notify", notify, 0);
    chk("R2", "popIsIpi", popIsIpi, 0);
    rstN = 1;
    @(posedge clk);

    // R4: pop on empty does nothing
    cycle(0, 0, 0, 1, "R4");

    // R1 / R7: a few events with and without notify, then drain in order
    cycle(1, 31'h7fffffff, 1, 0, "R1");
    cycle(1, 31'h0000_0005, 0, 0, "R7");
    cycle(1, 31'h1234_5678, 1, 0, "R1");
    for (int i = 0; i < 4; i++) cycle(0, 0, 0, 1, "R3");

    // R8: zero events are ignored
    cycle(1, 0, 1, 0, "R8");
    cycle(0, 0, 0, 1, "R8");

    // R9: inter-processor code at the head
    cycle(1, IPI, 0, 0, "R9");
    cycle(1, IPI + 1, 0, 0, "R9");
    cycle(0, 0, 0, 1, "R9");
    cycle(0, 0, 0, 1, "R9");

    // R6: fill completely, then overflow pushes
    for (int i = 0; i < DEPTH; i++) cycle(1, 31'(100 + i), 1, 0, "R6");
    cycle(1, 31'd999, 1, 0, "R6");
    cycle(1, 31'd998, 0, 0, "R6");
    // R10: push dropped even with a pop in the same cycle
    cycle(1, 31'd997, 1, 1, "R10");
    cycle(1, 31'd996, 1, 0, "R10");
    for (int i = 0; i < DEPTH + 1; i++) cycle(0, 0, 0, 1, "R6");

    // R3 / R5: long mixed stream across many wraps
    for (int i = 0; i < 600; i++) begin
      bit pv = ($urandom % 3) != 0;
      bit pr = ($urandom % 2) != 0;
      logic [30:0] ev = 31'($urandom) | 31'd1;
      if (($urandom % 20) == 0) ev = 0;
      cycle(pv, ev, ($urandom % 2) != 0, pr, "R5");
    end
    for (int i = 0; i < DEPTH + 2; i++) cycle(0, 0, 0, 1, "R3");

    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule